// File: doc/BRIEF.md
# Sample-Count PWM Interrupt Timer

This block raises a periodic interrupt for an audio PWM unit. Software programs a sample period, in ticks of a base clock enable, through a 12-bit cycle register. It programs an interrupt interval, in samples, through a 4-bit field of a control register. The block counts base ticks into completed samples and completed samples toward the interval. Each time the interval is reached it sets a sticky interrupt flag, which stays set until an acknowledge input clears it.

The programmed period is the cycle value minus one, wrapped to 12 bits. A cycle value of 1 gives a period of zero and halts sample counting. A cycle value of 0 wraps to the longest period, 4095 ticks. Writing the cycle register restarts sample timing from zero. An interval of zero turns interrupt generation off.

Top module: `pwm_sample_irq`

## Requirements
- R1: A write with `wr_sel`=1 loads the cycle register from `wr_data[11:0]`. Bits 15:12 of the write data are discarded and have no effect on timing.
- R2: With a nonzero period P = (cycle − 1) mod 4096, one sample completes on every P-th clock edge at which `base_ce` is high. Edges with `base_ce` low do not advance timing.
- R3: A write with `wr_sel`=0 loads the interval N from `wr_data[11:8]`. The other data bits are ignored.
- R4: While N is 0, `irq_flag` is never set and completed samples are not accumulated.
- R5: When a completed sample brings the accumulated count to N or beyond (N ≠ 0), N is subtracted from the count and `irq_flag` is set on that same clock edge.
- R6: A cycle register write resets the sample count and the tick position within the current sample to zero. A `base_ce` on the same edge is discarded.
- R7: `irq_clr` high at a clock edge clears `irq_flag`. If an interrupt fires on the same edge, the flag stays set.
- R8: `irq_flag` stays set until cleared. Intervals that elapse while it is set do not queue further interrupts, although the count keeps advancing.
- R9: A cycle value of 1, which gives period zero, stops all sample counting, so no interrupt can fire.
- R10: After reset, `irq_flag` is 0, the cycle register is 0 (period 4095), the interval is 0 and the sample count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_ce | input | 1 | Base clock enable; one tick of sample timing |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 1 = cycle register, 0 = control register |
| wr_data | input | 16 | Write data |
| irq_clr | input | 1 | Interrupt acknowledge; clears the flag |
| irq_flag | output | 1 | Sticky PWM interrupt flag |

## Verification
The assertions assume that software changes the period only through a cycle write, which also resets the tick position. On that basis the tick position always stays below the period, and a rising flag always follows a completed sample with a nonzero interval.

The random stimulus keeps most cycle values small, so that many samples complete within the run, and pulses `base_ce` irregularly. It mixes in writes with junk high bits, acknowledges that coincide with firing edges, and a stretch at the longest period, which is reached by way of the reset value.

// File: rtl/pwm_sample_irq.sv
module pwm_sample_irq #(
  parameter int CYC_W   = 12,
  parameter int IVL_W   = 4,
  parameter int DATA_W  = 16,
  parameter int IVL_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_ce,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_clr,
  output logic              irq_flag
);

  logic [CYC_W-1:0] cyc_q, div_q, period;
  logic [IVL_W-1:0] ivl_q, cnt_q;
  logic [IVL_W:0]   cnt_inc;
  logic             wr_cyc, wr_ctl, run, smp_done, fire;

  assign wr_cyc   = wr_en & wr_sel;
  assign wr_ctl   = wr_en & ~wr_sel;
  assign period   = cyc_q - CYC_W'(1);
  assign run      = base_ce & (period != '0) & ~wr_cyc;
  assign smp_done = run & (div_q == period - CYC_W'(1));
  assign cnt_inc  = {1'b0, cnt_q} + (IVL_W+1)'(1);
  assign fire     = smp_done & (ivl_q != '0) & (cnt_inc >= {1'b0, ivl_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q <= '0;
      ivl_q <= '0;
    end else begin
      if (wr_cyc) cyc_q <= wr_data[CYC_W-1:0];
      if (wr_ctl) ivl_q <= wr_data[IVL_LSB +: IVL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        div_q <= '0;
    else if (wr_cyc)   div_q <= '0;
    else if (smp_done) div_q <= '0;
    else if (run)      div_q <= div_q + CYC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (wr_cyc)                     cnt_q <= '0;
    else if (fire)                       cnt_q <= IVL_W'(cnt_inc - {1'b0, ivl_q});
    else if (smp_done && ivl_q != '0)    cnt_q <= IVL_W'(cnt_inc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_flag <= 1'b0;
    else if (fire)    irq_flag <= 1'b1;
    else if (irq_clr) irq_flag <= 1'b0;
  end

  a_r2_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0) |-> (div_q < period));

  a_r4_rise_needs_interval: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> ($past(ivl_q) != '0 && $past(smp_done)));

  a_r6_cycle_write_resets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cyc |=> (cnt_q == '0 && div_q == '0));

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !fire) |=> !irq_flag);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  a_r9_zero_period_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0 && !wr_cyc) |=> ($stable(cnt_q) && $stable(irq_flag | irq_clr) || !irq_flag));

endmodule

// File: tb/pwm_sample_irq_test.sv
`timescale 1ns/1ps
module pwm_sample_irq_test;
  logic clk = 1'b0, rst_n = 1'b0, base_ce = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, irq_clr = 1'b0;
  logic [15:0] wr_data = '0;
  logic irq_flag;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [11:0] m_cyc, m_div;
  logic [3:0]  m_ivl, m_cnt;
  logic        m_flag;

  always #5 clk = ~clk;

  pwm_sample_irq uut (.clk(clk), .rst_n(rst_n), .base_ce(base_ce), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .irq_clr(irq_clr), .irq_flag(irq_flag));

  function automatic logic [11:0] period_of(input logic [11:0] c);
    return c - 12'd1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq_flag=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [11:0] p;
    logic [4:0]  inc;
    logic        done_s, set;
    p = period_of(m_cyc);
    set = 1'b0;
    if (wr_en && wr_sel) begin
      m_div = '0; m_cnt = '0;
    end else if (base_ce && p != 0) begin
      done_s = (m_div + 12'd1 == p);
      m_div  = done_s ? 12'd0 : m_div + 12'd1;
      if (done_s && m_ivl != 0) begin
        inc = {1'b0, m_cnt} + 5'd1;
        if (inc >= {1'b0, m_ivl}) begin
          set = 1'b1;
          inc = inc - {1'b0, m_ivl};
        end
        m_cnt = inc[3:0];
      end
    end
    if (set) m_flag = 1'b1;
    else if (irq_clr) m_flag = 1'b0;
    if (wr_en && wr_sel)  m_cyc = wr_data[11:0];
    if (wr_en && !wr_sel) m_ivl = wr_data[11:8];
  endtask

  task automatic step(input logic ce, input logic we, input logic sel,
                      input logic [15:0] d, input logic clr, input string req);
    base_ce = ce; wr_en = we; wr_sel = sel; wr_data = d; irq_clr = clr;
    @(posedge clk);
    model_edge();
    #1;
    check(req, irq_flag, m_flag);
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 16'h0, 1'b0, req);
  endtask

  initial begin
    m_cyc = '0; m_div = '0; m_ivl = '0; m_cnt = '0; m_flag = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R10", irq_flag, 1'b0);
    step(1'b0, 1'b1, 1'b0, 16'h0100, 1'b0, "R3");
    ticks(4094, "R10");
    check("R10", irq_flag, 1'b0);
    ticks(1, "R10");
    check("R10", irq_flag, 1'b1);
    step(1'b0, 1'b0, 1'b0, 16'h0, 1'b1, "R7");
    check("R7", irq_flag, 1'b0);

    step(1'b0, 1'b1, 1'b1, 16'hF003, 1'b0, "R1");
    step(1'b0, 1'b1, 1'b0, 16'hF2FF, 1'b0, "R3");
    ticks(3, "R1");
    check("R1", irq_flag, 1'b0);
    ticks(1, "R5");
    check("R5", irq_flag, 1'b1);
    ticks(12, "R8");
    check("R8", irq_flag, 1'b1);
    step(1'b0, 1'b0, 1'b0, 16'h0, 1'b1, "R8");
    check("R8", irq_flag, 1'b0);

    step(1'b0, 1'b1, 1'b1, 16'h0002, 1'b0, "R6");
    step(1'b0, 1'b1, 1'b0, 16'h0100, 1'b0, "R3");
    step(1'b1, 1'b0, 1'b0, 16'h0, 1'b1, "R7");
    check("R7", irq_flag, 1'b1);
    step(1'b0, 1'b0, 1'b0, 16'h0, 1'b1, "R7");

    step(1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, "R4");
    ticks(20, "R4");
    check("R4", irq_flag, 1'b0);
    step(1'b0, 1'b1, 1'b0, 16'h0300, 1'b0, "R4");
    ticks(2, "R4");
    check("R4", irq_flag, 1'b0);
    ticks(1, "R4");
    check("R4", irq_flag, 1'b1);
    step(1'b0, 1'b0, 1'b0, 16'h0, 1'b1, "R7");

    step(1'b0, 1'b1, 1'b1, 16'h0001, 1'b0, "R9");
    step(1'b0, 1'b1, 1'b0, 16'h0100, 1'b0, "R9");
    ticks(50, "R9");
    check("R9", irq_flag, 1'b0);

    step(1'b0, 1'b1, 1'b1, 16'h0005, 1'b0, "R6");
    ticks(3, "R6");
    step(1'b1, 1'b1, 1'b1, 16'h0005, 1'b0, "R6");
    ticks(3, "R6");
    check("R6", irq_flag, 1'b0);
    ticks(1, "R6");
    check("R6", irq_flag, 1'b1);
    step(1'b0, 1'b0, 1'b0, 16'h0, 1'b1, "R7");

    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 6000; i++) begin
      logic we, sel, ce, clr;
      logic [15:0] d;
      we  = ($urandom % 100) < 4;
      sel = $urandom % 2;
      ce  = ($urandom % 100) < 70;
      clr = ($urandom % 100) < 8;
      d   = $urandom;
      if (we && sel) d = {d[15:12], 9'd0, d[2:0] & 3'd7};
      step(ce, we, sel, d, clr, "R2");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule